// File: doc/BRIEF.md
# Sixteen-Pin Parallel Port with Bus Address Override

This block is a 16-pin bidirectional general-purpose port, organised as a low byte (pins 0..7) and a high byte (pins 8..15). Each byte has an output latch and a direction latch. Software reaches them through a four-word register interface. Writes take effect at the next clock edge. Read data is a combinational function of the register select.

A bus-mode input lets an external bus controller take the pins over. While bus mode is high, every pin is driven as an output. The output latches then load from a 16-bit address word whenever the controller's address-valid strobe is high, and software writes to the output latches are dropped. Direction writes made in bus mode are still kept. When bus mode falls, the software direction setting is in force again.

Pin levels pass through a multi-flop synchronizer before software reads them. The four upper pins of the high byte also feed a capture-input bus for a timer unit. Pad drivers, the bus controller and the capture logic are outside this block.

Top module: `gpio16_busport`

## Requirements
- R1: While reset is asserted, both output latches and both direction latches are zero. With bus mode low, `pin_oe` and `pin_out` are then all zero.
- R2: With bus mode low, a write to register select 0 loads `pin_out[7:0]` and a write to select 2 loads `pin_out[15:8]`. The new value is visible after the write edge.
- R3: A write to select 1 sets the low-byte direction bits and a write to select 3 sets the high-byte direction bits. A bit of 1 makes the matching pin an output (`pin_oe` = 1) when bus mode is low. Reading select 1 or 3 returns the stored direction byte.
- R4: In the same cycle that bus mode is high, `pin_oe` is all ones, whatever the direction latches hold.
- R5: With bus mode high, a clock edge with `bus_addr_valid` high loads `pin_out` with `bus_addr`, bit i to pin i. An edge with the strobe low leaves `pin_out` unchanged.
- R6: With bus mode high, software writes to select 0 or 2 have no effect on `pin_out`. This holds even in the cycle where the address strobe loads the latch.
- R7: Direction writes made while bus mode is high are stored. When bus mode falls, `pin_oe` equals the last direction bytes written.
- R8: Reading select 0 returns pins 7..0 and reading select 2 returns pins 15..8. The value read is the pin level after two clock edges of synchronisation, and a pin change is not visible after only one edge.
- R9: `cap_in[3:0]` equals synchronised pins 12..15, with `cap_in[0]` taken from pin 12.
- R10: When bus mode falls, the output latches keep the last loaded address until software writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable, one cycle |
| reg_addr | input | 2 | Register select: 0 low data, 1 low direction, 2 high data, 3 high direction |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| bus_mode | input | 1 | External bus mode: bus controller owns the pins |
| bus_addr_valid | input | 1 | Address-valid strobe from the bus controller |
| bus_addr | input | 16 | Address word driven onto the pins in bus mode |
| pin_in | input | 16 | Pin levels seen at the pads |
| pin_out | output | 16 | Output latch value to the pad drivers |
| pin_oe | output | 16 | Per-pin output enable for the tri-state drivers |
| cap_in | output | 4 | Synchronised upper high-byte pins for the capture unit |

## Verification
Two things can coincide in a single clock edge: a software write to a data register and a bus-controller address load. The bench provokes this by raising the address strobe with a new address in the same cycle as a write to select 0. It passes only if `pin_out` shows the address and no trace of the software byte. A direction write and an active bus mode can also overlap. That case is judged by reading the direction register back while `pin_oe` stays all ones, then checking `pin_oe` against the stored byte once bus mode drops.

// File: rtl/busport_pkg.sv
package busport_pkg;
   localparam int REG_AW = 2;

   typedef enum logic [REG_AW-1:0] {
      SEL_LO_DATA = 2'd0,
      SEL_LO_DIR  = 2'd1,
      SEL_HI_DATA = 2'd2,
      SEL_HI_DIR  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/busport_sync.sv
module busport_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/busport_half.sv
module busport_half #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         data_we,
   input  logic         dir_we,
   input  logic [W-1:0] wdata,
   input  logic         bus_mode,
   input  logic         bus_load,
   input  logic [W-1:0] bus_bits,
   output logic [W-1:0] out_lat,
   output logic [W-1:0] dir_lat,
   output logic [W-1:0] oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_lat <= '0;
         dir_lat <= '0;
      end else begin
         // direction writes are always kept, even while the bus owns the pins
         if (dir_we) dir_lat <= wdata;
         // bus ownership wins over software for the output latch
         if (bus_mode) begin
            if (bus_load) out_lat <= bus_bits;
         end else if (data_we) begin
            out_lat <= wdata;
         end
      end
   end

   assign oe = bus_mode ? {W{1'b1}} : dir_lat;
endmodule

// File: rtl/gpio16_busport.sv
module gpio16_busport
   import busport_pkg::*;
#(
   parameter int HALF_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CAP_N       = 4,
   parameter int CAP_LSB     = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [HALF_W-1:0]   reg_wdata,
   output logic [HALF_W-1:0]   reg_rdata,
   input  logic                bus_mode,
   input  logic                bus_addr_valid,
   input  logic [2*HALF_W-1:0] bus_addr,
   input  logic [2*HALF_W-1:0] pin_in,
   output logic [2*HALF_W-1:0] pin_out,
   output logic [2*HALF_W-1:0] pin_oe,
   output logic [CAP_N-1:0]    cap_in
);
   localparam int N_HALF = 2;
   localparam int PIN_W  = N_HALF * HALF_W;
   localparam int CAP_AT = HALF_W + CAP_LSB;

   if (HALF_W < 1) begin : g_bad_width
      $error("HALF_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CAP_LSB + CAP_N > HALF_W) begin : g_bad_cap
      $error("capture pins must lie inside the high half");
   end

   logic [PIN_W-1:0]  sync_q;
   logic [PIN_W-1:0]  out_lat;
   logic [PIN_W-1:0]  dir_lat;
   logic [PIN_W-1:0]  oe_w;

   busport_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_q)
   );

   for (genvar h = 0; h < N_HALF; h++) begin : g_half
      logic hsel;
      assign hsel = (reg_addr[1] == 1'(h));

      busport_half #(.W(HALF_W)) u_half (
         .clk      (clk),
         .rst_n    (rst_n),
         .data_we  (reg_we && hsel && !reg_addr[0]),
         .dir_we   (reg_we && hsel &&  reg_addr[0]),
         .wdata    (reg_wdata),
         .bus_mode (bus_mode),
         .bus_load (bus_addr_valid),
         .bus_bits (bus_addr[h*HALF_W +: HALF_W]),
         .out_lat  (out_lat[h*HALF_W +: HALF_W]),
         .dir_lat  (dir_lat[h*HALF_W +: HALF_W]),
         .oe       (oe_w[h*HALF_W +: HALF_W])
      );
   end

   assign pin_out = out_lat;
   assign pin_oe  = oe_w;
   assign cap_in  = sync_q[CAP_AT +: CAP_N];

   always_comb begin
      unique case (reg_sel_e'(reg_addr))
         SEL_LO_DATA: reg_rdata = sync_q[HALF_W-1:0];
         SEL_LO_DIR:  reg_rdata = dir_lat[HALF_W-1:0];
         SEL_HI_DATA: reg_rdata = sync_q[PIN_W-1:HALF_W];
         SEL_HI_DIR:  reg_rdata = dir_lat[PIN_W-1:HALF_W];
         default:     reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/busport_chk.sv
module busport_chk #(
   parameter int HALF_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CAP_N       = 4,
   parameter int CAP_LSB     = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_we,
   input logic [1:0]          reg_addr,
   input logic [HALF_W-1:0]   reg_wdata,
   input logic                bus_mode,
   input logic                bus_addr_valid,
   input logic [2*HALF_W-1:0] bus_addr,
   input logic [2*HALF_W-1:0] pin_in,
   input logic [2*HALF_W-1:0] pin_out,
   input logic [2*HALF_W-1:0] pin_oe,
   input logic [CAP_N-1:0]    cap_in
);
   localparam int CAP_AT = HALF_W + CAP_LSB;

   int unsigned up_cycles;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) up_cycles <= 0;
      else if (up_cycles < SYNC_STAGES + 1) up_cycles <= up_cycles + 1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      (!rst_n && !bus_mode) |-> (pin_oe == '0 && pin_out == '0));

   // R2
   sw_low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_mode && reg_we && reg_addr == 2'd0) |=> (pin_out[HALF_W-1:0] == $past(reg_wdata)));

   // R4
   bus_oe_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_mode |-> (pin_oe == '1));

   // R5
   bus_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mode && bus_addr_valid) |=> (pin_out == $past(bus_addr)));

   // R6
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mode && !bus_addr_valid) |=> $stable(pin_out));

   // R9
   cap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cycles > SYNC_STAGES) |-> (cap_in == $past(pin_in[CAP_AT +: CAP_N], SYNC_STAGES)));
endmodule

bind gpio16_busport busport_chk #(
   .HALF_W(HALF_W), .SYNC_STAGES(SYNC_STAGES), .CAP_N(CAP_N), .CAP_LSB(CAP_LSB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .bus_mode(bus_mode), .bus_addr_valid(bus_addr_valid),
   .bus_addr(bus_addr), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
   .cap_in(cap_in)
);

// File: tb/test_gpio16_busport.sv
module test_gpio16_busport;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        bus_mode = 1'b0;
   logic        bus_addr_valid = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic [15:0] pin_in;
   logic [15:0] pin_out;
   logic [15:0] pin_oe;
   logic [3:0]  cap_in;
   logic [15:0] ext = 16'h0000;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // pad model: driven pins read back their own output
   for (genvar i = 0; i < 16; i++) begin : g_pad
      assign pin_in[i] = pin_oe[i] ? pin_out[i] : ext[i];
   end

   gpio16_busport i_gpio16_busport (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_mode(bus_mode),
      .bus_addr_valid(bus_addr_valid), .bus_addr(bus_addr), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .cap_in(cap_in)
   );

   // {sel, wdata, expected pin_oe, expected pin_out}
   localparam logic [41:0] VEC [6] = '{
      {2'd1, 8'h0F, 16'h000F, 16'h0000},
      {2'd0, 8'hA5, 16'h000F, 16'h00A5},
      {2'd3, 8'hF0, 16'hF00F, 16'h00A5},
      {2'd2, 8'h3C, 16'hF00F, 16'h3CA5},
      {2'd1, 8'hFF, 16'hF0FF, 16'h3CA5},
      {2'd2, 8'hC3, 16'hF0FF, 16'hC3A5}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [7:0] r;
      #1 rst_n = 1'b0;
      idle(2);
      // R1 reset state
      check("R1 oe in reset", pin_oe, 16'h0000);
      check("R1 out in reset", pin_out, 16'h0000);
      rd(2'd1, r); check("R1 dir lo in reset", {8'h00, r}, 16'h0000);
      rst_n = 1'b1;
      idle(1);

      // R2 R3 table walk
      for (int i = 0; i < 6; i++) begin
         wr(VEC[i][41:40], VEC[i][39:32]);
         check("R3 oe after write", pin_oe, VEC[i][31:16]);
         check("R2 out after write", pin_out, VEC[i][15:0]);
         if (VEC[i][40]) begin
            rd(VEC[i][41:40], r);
            check("R3 dir readback", {8'h00, r}, {8'h00, VEC[i][39:32]});
         end
      end

      // R8 R9 mixed pins: lo all out (A5), hi 15..12 out (C), 11..8 in
      ext = 16'h5A5A;
      idle(3);
      rd(2'd0, r); check("R8 read lo", {8'h00, r}, 16'h00A5);
      rd(2'd2, r); check("R8 read hi mixed", {8'h00, r}, 16'h00CA);
      check("R9 cap from driven pins", {12'h000, cap_in}, 16'h000C);

      wr(2'd1, 8'h00);
      wr(2'd3, 8'h00);
      idle(3);
      rd(2'd0, r); check("R8 read lo input", {8'h00, r}, 16'h005A);
      check("R9 cap from inputs", {12'h000, cap_in}, 16'h0005);

      // R8 synchronizer latency
      @(negedge clk); ext = 16'h9123;
      @(negedge clk);
      rd(2'd2, r); check("R8 not yet after one edge", {8'h00, r}, 16'h005A);
      @(negedge clk);
      rd(2'd2, r); check("R8 visible after two edges", {8'h00, r}, 16'h0091);
      rd(2'd0, r); check("R8 lo after two edges", {8'h00, r}, 16'h0023);
      check("R9 cap after two edges", {12'h000, cap_in}, 16'h0009);

      // R4 R5 bus mode
      wr(2'd1, 8'h0F);
      @(negedge clk); bus_mode = 1'b1; bus_addr = 16'h1234; bus_addr_valid = 1'b0;
      #1 check("R4 oe forced same cycle", pin_oe, 16'hFFFF);
      @(negedge clk);
      check("R5 hold without strobe", pin_out, 16'hC3A5);
      bus_addr_valid = 1'b1;
      @(negedge clk);
      check("R5 address load", pin_out, 16'h1234);

      // R6 collision: software write and address load in one edge
      bus_addr = 16'hBEEF;
      wr(2'd0, 8'h11);
      check("R6 collision bus wins", pin_out, 16'hBEEF);
      bus_addr_valid = 1'b0;
      wr(2'd2, 8'h77);
      check("R6 data write ignored", pin_out, 16'hBEEF);

      // R7 direction write stored during bus mode
      wr(2'd3, 8'h81);
      rd(2'd3, r); check("R7 dir stored in bus mode", {8'h00, r}, 16'h0081);
      check("R4 oe still forced", pin_oe, 16'hFFFF);
      bus_mode = 1'b0;
      #1 check("R7 dir restored", pin_oe, 16'h810F);
      @(negedge clk);
      check("R10 latch keeps address", pin_out, 16'hBEEF);
      wr(2'd0, 8'h42);
      check("R2 software regains latch", pin_out, 16'hBE42);

      // R1 reset mid-run
      rst_n = 1'b0;
      #1;
      check("R1 oe after reset", pin_oe, 16'h0000);
      check("R1 out after reset", pin_out, 16'h0000);
      rd(2'd3, r); check("R1 dir hi after reset", {8'h00, r}, 16'h0000);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule